// File: doc/BRIEF.md
# Internal and External Data Space Router

This block sits between the operand-fetch logic of an 8051-class core and the storage that backs its data spaces. Each cycle it takes one internal access (an 8-bit address, a flag saying whether the address came from a direct operand or from a pointer register, a flag saying whether it is a bit operand or a working-register operand, and read/write strobes) and decides which storage answers it. The candidates are the lower 128 bytes of RAM, the upper 128 bytes of RAM, and a paged bank of special function registers. A second port carries the 16-bit address used by external-data moves. The block steers that access either to an 8 KiB on-chip XRAM or to the off-chip bus.

In the upper half of the internal space (0x80 to 0xFF), the addressing mode picks the storage. Pointer-based accesses land in upper RAM. Direct accesses land in the special function register file, on the page currently held in the page register. Bit operands are turned into a byte offset and a bit index. Working-register operands R0 to R7 are relocated into the register bank chosen by the two bank-select bits.

All outputs are registered. They describe the access that was presented one clock earlier. The contents of RAM and of the special function registers live outside this block.

Top module: `dmem_router`

## Requirements
- R1: The reset is synchronous and active low. While it is applied, every select, address, page, bit and write output reads zero. Outside reset, the outputs show the access presented at the previous rising edge.
- R2: A byte access (no register flag, no bit flag) to addresses 0x00 to 0x7F selects lower RAM with offset equal to the address, in both direct and indirect mode.
- R3: An indirect byte access to addresses 0x80 to 0xFF selects upper RAM, with offset equal to the address minus 0x80.
- R4: A direct byte access to addresses 0x80 to 0xFF selects the special function register file. The offset is the address minus 0x80, and the page output equals the page register.
- R5: A bit access to a bit address below 0x80 selects lower RAM at byte 0x20 + (address >> 3). The bit index is (address & 7) and the bit-valid output is 1. The mode flag is ignored.
- R6: A bit access to a bit address of 0x80 or above selects the special function register file at byte (address & 0xF8), which is offset (address & 0x78). The bit index is (address & 7), bit-valid is 1, and the page output equals the page register.
- R7: A register access selects lower RAM at 8 × bank + (address & 7). The register flag overrides the bit flag, and the bit flag overrides the mode flag.
- R8: An external access with address 0x0000 to 0x1FFF selects on-chip XRAM with the low 13 address bits as offset.
- R9: An external access with address 0x2000 to 0xFFFF selects the off-chip bus with the full 16-bit address.
- R10: Exactly one select is high for a cycle in which any strobe was active. When internal and external strobes coincide, the internal access wins and the external one is dropped.
- R11: With no strobe active, all selects are low and all address, page, bit and write outputs are zero. Each address output is also zero whenever its own select is low.
- R12: The write output is high when the winning access had its write strobe set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ia_addr | input | 8 | Internal address, bit address, or register number in bits 2:0 |
| ia_indirect | input | 1 | 1 = address came from a pointer register, 0 = direct operand |
| ia_bit | input | 1 | Address is a bit address |
| ia_reg | input | 1 | Address is a working-register number R0 to R7 |
| ia_rd | input | 1 | Internal read strobe |
| ia_wr | input | 1 | Internal write strobe |
| bank_sel | input | 2 | Active working-register bank |
| sfr_page_in | input | 8 | Current special function register page |
| xa_addr | input | 16 | External-data address |
| xa_rd | input | 1 | External read strobe |
| xa_wr | input | 1 | External write strobe |
| sel_lram | output | 1 | Lower RAM selected |
| sel_hram | output | 1 | Upper RAM selected |
| sel_sfr | output | 1 | Special function register file selected |
| sel_xram | output | 1 | On-chip XRAM selected |
| sel_xbus | output | 1 | Off-chip bus selected |
| lram_off | output | 7 | Lower RAM byte offset |
| hram_off | output | 7 | Upper RAM byte offset |
| sfr_off | output | 7 | Register offset within the page |
| sfr_page | output | 8 | Page for the register access |
| xram_off | output | 13 | XRAM byte offset |
| xbus_addr | output | 16 | Off-chip address |
| bit_vld | output | 1 | Access is a single bit |
| bit_idx | output | 3 | Bit position in the selected byte |
| acc_we | output | 1 | Access is a write |

## Verification
On every cycle, the assertions check the following:
- Any strobe yields exactly one select and no strobe yields none.
- Upper RAM is only reached by a pointer-based byte access.
- The register file is never reached by a pointer-based byte access.
- XRAM is only chosen for external addresses inside its 8 KiB window.

The offsets only the bench scenarios can show are these:
- The offset arithmetic: the 0x20 base for bit bytes, the 0xF8 masking for register bits, and bank relocation.
- The order of precedence between the register, bit and mode flags.
- Page forwarding, and the edges of each address range (0x7F/0x80, 0x1FFF/0x2000, 0xFFFF).

// File: rtl/dmr_pkg.sv
// Shared types for the data-space router.
// Assumes at most one access is described per route record.
package dmr_pkg;
    typedef enum logic [2:0] {
        TGT_NONE = 3'd0,
        TGT_LRAM = 3'd1,
        TGT_HRAM = 3'd2,
        TGT_SFR  = 3'd3,
        TGT_XRAM = 3'd4,
        TGT_XBUS = 3'd5
    } tgt_e;

    typedef struct packed {
        tgt_e       tgt;
        logic [6:0] off;
        logic       bit_en;
        logic [2:0] bit_idx;
    } int_route_t;
endpackage

// File: rtl/dmr_bit_map.sv
// Expands an 8-bit bit address into a byte offset and a bit index.
// Bit addresses below 0x80 map to lower RAM bytes 0x20..0x2F.
// Bit addresses at or above 0x80 map to register-file bytes whose address ends in 0 or 8.
// Purely combinational; assumes an 8-bit internal space.
module dmr_bit_map (
    input  logic [7:0] bit_addr,
    output logic       in_sfr,
    output logic [6:0] byte_off,
    output logic [2:0] idx
);
    localparam logic [6:0] BIT_BASE = 7'h20;

    // Choose the byte holding the bit, and the position of the bit in it.
    always_comb begin
        in_sfr = bit_addr[7];
        idx    = bit_addr[2:0];
        if (bit_addr[7])
            byte_off = {bit_addr[6:3], 3'b000};
        else
            byte_off = BIT_BASE + {3'b000, bit_addr[6:3]};
    end
endmodule

// File: rtl/dmr_int_decode.sv
// Resolves one internal access to lower RAM, upper RAM or the register file.
// Precedence: register operand, then bit operand, then byte by mode.
// Combinational; the caller qualifies the result with the strobes.
module dmr_int_decode
    import dmr_pkg::*;
#(
    parameter int BANK_W = 2
) (
    input  logic [7:0]        addr,
    input  logic              indirect,
    input  logic              is_bit,
    input  logic              is_reg,
    input  logic [BANK_W-1:0] bank,
    output int_route_t        route
);
    localparam int REG_W = 3;
    localparam int PAD_W = 7 - BANK_W - REG_W;

    logic       bm_sfr;
    logic [6:0] bm_off;
    logic [2:0] bm_idx;

    dmr_bit_map u_bit_map (
        .bit_addr (addr),
        .in_sfr   (bm_sfr),
        .byte_off (bm_off),
        .idx      (bm_idx)
    );

    // Apply the precedence and produce the target and offset.
    always_comb begin
        route = '{tgt: TGT_NONE, off: 7'd0, bit_en: 1'b0, bit_idx: 3'd0};
        if (is_reg) begin
            route.tgt = TGT_LRAM;
            route.off = {{PAD_W{1'b0}}, bank, addr[REG_W-1:0]};
        end else if (is_bit) begin
            route.tgt     = bm_sfr ? TGT_SFR : TGT_LRAM;
            route.off     = bm_off;
            route.bit_en  = 1'b1;
            route.bit_idx = bm_idx;
        end else if (!addr[7]) begin
            route.tgt = TGT_LRAM;
            route.off = addr[6:0];
        end else begin
            route.tgt = indirect ? TGT_HRAM : TGT_SFR;
            route.off = addr[6:0];
        end
    end
endmodule

// File: rtl/dmr_ext_decode.sv
// Splits the external-data address space into on-chip XRAM and the off-chip bus.
// XRAM occupies the lowest 2**XRAM_AW bytes; everything above goes off chip.
module dmr_ext_decode #(
    parameter int XA_W    = 16,
    parameter int XRAM_AW = 13
) (
    input  logic [XA_W-1:0]    xaddr,
    output logic               to_xram,
    output logic [XRAM_AW-1:0] xram_off
);
    // An address is in XRAM when all bits above the XRAM window are zero.
    always_comb begin
        to_xram  = (xaddr[XA_W-1:XRAM_AW] == '0);
        xram_off = xaddr[XRAM_AW-1:0];
    end
endmodule

// File: rtl/dmem_router.sv
// Top of the data-space router. It arbitrates internal over external strobes.
// It registers one-hot selects and the per-target offsets for one cycle of latency.
// Address outputs are zero unless their own select is set.
module dmem_router
    import dmr_pkg::*;
#(
    parameter int BANK_W  = 2,
    parameter int PAGE_W  = 8,
    parameter int XA_W    = 16,
    parameter int XRAM_AW = 13
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [7:0]         ia_addr,
    input  logic               ia_indirect,
    input  logic               ia_bit,
    input  logic               ia_reg,
    input  logic               ia_rd,
    input  logic               ia_wr,
    input  logic [BANK_W-1:0]  bank_sel,
    input  logic [PAGE_W-1:0]  sfr_page_in,
    input  logic [XA_W-1:0]    xa_addr,
    input  logic               xa_rd,
    input  logic               xa_wr,
    output logic               sel_lram,
    output logic               sel_hram,
    output logic               sel_sfr,
    output logic               sel_xram,
    output logic               sel_xbus,
    output logic [6:0]         lram_off,
    output logic [6:0]         hram_off,
    output logic [6:0]         sfr_off,
    output logic [PAGE_W-1:0]  sfr_page,
    output logic [XRAM_AW-1:0] xram_off,
    output logic [XA_W-1:0]    xbus_addr,
    output logic               bit_vld,
    output logic [2:0]         bit_idx,
    output logic               acc_we
);
    int_route_t         iroute;
    logic               ext_xram;
    logic [XRAM_AW-1:0] ext_off;
    logic               int_go, ext_go;
    tgt_e               tgt_n;

    dmr_int_decode #(.BANK_W(BANK_W)) u_int (
        .addr     (ia_addr),
        .indirect (ia_indirect),
        .is_bit   (ia_bit),
        .is_reg   (ia_reg),
        .bank     (bank_sel),
        .route    (iroute)
    );

    dmr_ext_decode #(.XA_W(XA_W), .XRAM_AW(XRAM_AW)) u_ext (
        .xaddr    (xa_addr),
        .to_xram  (ext_xram),
        .xram_off (ext_off)
    );

    // Arbitrate: an internal strobe blocks any external strobe in the same cycle.
    always_comb begin
        int_go = ia_rd | ia_wr;
        ext_go = !int_go && (xa_rd | xa_wr);
        if (int_go)      tgt_n = iroute.tgt;
        else if (ext_go) tgt_n = ext_xram ? TGT_XRAM : TGT_XBUS;
        else             tgt_n = TGT_NONE;
    end

    // Register the selects and zero every field that does not belong to the winner.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_lram  <= 1'b0;
            sel_hram  <= 1'b0;
            sel_sfr   <= 1'b0;
            sel_xram  <= 1'b0;
            sel_xbus  <= 1'b0;
            lram_off  <= '0;
            hram_off  <= '0;
            sfr_off   <= '0;
            sfr_page  <= '0;
            xram_off  <= '0;
            xbus_addr <= '0;
            bit_vld   <= 1'b0;
            bit_idx   <= '0;
            acc_we    <= 1'b0;
        end else begin
            sel_lram  <= (tgt_n == TGT_LRAM);
            sel_hram  <= (tgt_n == TGT_HRAM);
            sel_sfr   <= (tgt_n == TGT_SFR);
            sel_xram  <= (tgt_n == TGT_XRAM);
            sel_xbus  <= (tgt_n == TGT_XBUS);
            lram_off  <= (tgt_n == TGT_LRAM) ? iroute.off : '0;
            hram_off  <= (tgt_n == TGT_HRAM) ? iroute.off : '0;
            sfr_off   <= (tgt_n == TGT_SFR)  ? iroute.off : '0;
            sfr_page  <= (tgt_n == TGT_SFR)  ? sfr_page_in : '0;
            xram_off  <= (tgt_n == TGT_XRAM) ? ext_off : '0;
            xbus_addr <= (tgt_n == TGT_XBUS) ? xa_addr : '0;
            bit_vld   <= int_go && iroute.bit_en;
            bit_idx   <= (int_go && iroute.bit_en) ? iroute.bit_idx : '0;
            acc_we    <= int_go ? ia_wr : (ext_go && xa_wr);
        end
    end

    // R10: any strobe in the previous cycle gives exactly one select.
    assert_one_target_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ia_rd | ia_wr | xa_rd | xa_wr))
            |-> ($countones({sel_lram, sel_hram, sel_sfr, sel_xram, sel_xbus}) == 1));

    // R11: no strobe in the previous cycle gives no select.
    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(ia_rd | ia_wr | xa_rd | xa_wr))
            |-> ({sel_lram, sel_hram, sel_sfr, sel_xram, sel_xbus} == 5'b0));

    // R3: upper RAM is reached only by a pointer-based byte access above 0x7F.
    assert_hram_indirect_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sel_hram |-> ($past(ia_indirect) && !$past(ia_bit) && !$past(ia_reg) && $past(ia_addr[7])));

    // R4: the register file is never reached through a pointer-based byte access.
    assert_sfr_not_indirect_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sel_sfr |-> (!$past(ia_indirect) || $past(ia_bit)));

    // R8: XRAM is chosen only for addresses inside its window.
    assert_xram_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sel_xram |-> ($past(xa_addr[XA_W-1:XRAM_AW]) == '0));
endmodule

// File: tb/dmem_router_tb_top.sv
`timescale 1ns/1ps
module dmem_router_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  ia_addr = '0;
    logic        ia_indirect = 1'b0, ia_bit = 1'b0, ia_reg = 1'b0;
    logic        ia_rd = 1'b0, ia_wr = 1'b0;
    logic [1:0]  bank_sel = '0;
    logic [7:0]  sfr_page_in = '0;
    logic [15:0] xa_addr = '0;
    logic        xa_rd = 1'b0, xa_wr = 1'b0;
    logic        sel_lram, sel_hram, sel_sfr, sel_xram, sel_xbus;
    logic [6:0]  lram_off, hram_off, sfr_off;
    logic [7:0]  sfr_page;
    logic [12:0] xram_off;
    logic [15:0] xbus_addr;
    logic        bit_vld, acc_we;
    logic [2:0]  bit_idx;

    int total = 0;
    int bad = 0;

    typedef struct {
        logic [67:0] v;
        string       req;
    } item_t;
    item_t sb_q[$];

    always #4 clk = ~clk;

    dmem_router dut_i (
        .clk(clk), .rst_n(rst_n), .ia_addr(ia_addr), .ia_indirect(ia_indirect),
        .ia_bit(ia_bit), .ia_reg(ia_reg), .ia_rd(ia_rd), .ia_wr(ia_wr),
        .bank_sel(bank_sel), .sfr_page_in(sfr_page_in), .xa_addr(xa_addr),
        .xa_rd(xa_rd), .xa_wr(xa_wr), .sel_lram(sel_lram), .sel_hram(sel_hram),
        .sel_sfr(sel_sfr), .sel_xram(sel_xram), .sel_xbus(sel_xbus),
        .lram_off(lram_off), .hram_off(hram_off), .sfr_off(sfr_off),
        .sfr_page(sfr_page), .xram_off(xram_off), .xbus_addr(xbus_addr),
        .bit_vld(bit_vld), .bit_idx(bit_idx), .acc_we(acc_we)
    );

    function automatic logic [67:0] observed();
        return {sel_lram, sel_hram, sel_sfr, sel_xram, sel_xbus, lram_off, hram_off,
                sfr_off, sfr_page, xram_off, xbus_addr, bit_vld, bit_idx, acc_we};
    endfunction

    // Reference model written from the requirement list.
    function automatic logic [67:0] model(input logic [7:0] a, input logic ind, input logic bt,
            input logic rg, input logic rd, input logic wr, input logic [1:0] bk,
            input logic [7:0] pg, input logic [15:0] xa, input logic xr, input logic xw);
        logic [4:0] s = '0; logic [6:0] lo = '0, hi = '0, so = '0; logic [7:0] sp = '0;
        logic [12:0] xo = '0; logic [15:0] xb = '0; logic bv = 1'b0; logic [2:0] bi = '0;
        logic we = 1'b0;
        if (rd || wr) begin
            we = wr;
            if (rg) begin s = 5'b10000; lo = 7'(bk * 8 + a % 8); end
            else if (bt) begin
                bv = 1'b1; bi = 3'(a % 8);
                if (a < 8'h80) begin s = 5'b10000; lo = 7'(8'h20 + a / 8); end
                else begin s = 5'b00100; so = 7'((a & 8'hF8) - 8'h80); sp = pg; end
            end else if (a < 8'h80) begin s = 5'b10000; lo = a[6:0]; end
            else if (ind) begin s = 5'b01000; hi = 7'(a - 8'h80); end
            else begin s = 5'b00100; so = 7'(a - 8'h80); sp = pg; end
        end else if (xr || xw) begin
            we = xw;
            if (xa < 16'h2000) begin s = 5'b00010; xo = xa[12:0]; end
            else begin s = 5'b00001; xb = xa; end
        end
        return {s, lo, hi, so, sp, xo, xb, bv, bi, we};
    endfunction

    // Driver: present one access at the falling edge and queue its expected result.
    task automatic issue(input string req, input logic [7:0] a, input logic ind, input logic bt,
            input logic rg, input logic rd, input logic wr, input logic [1:0] bk,
            input logic [7:0] pg, input logic [15:0] xa, input logic xr, input logic xw);
        item_t it;
        @(negedge clk);
        ia_addr = a; ia_indirect = ind; ia_bit = bt; ia_reg = rg; ia_rd = rd; ia_wr = wr;
        bank_sel = bk; sfr_page_in = pg; xa_addr = xa; xa_rd = xr; xa_wr = xw;
        it.v = model(a, ind, bt, rg, rd, wr, bk, pg, xa, xr, xw);
        it.req = req;
        sb_q.push_back(it);
    endtask

    // Monitor: after each rising edge, compare the registered outputs with the queue head.
    always @(posedge clk) begin
        #2;
        if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            total++;
            if (observed() !== it.v) begin
                bad++;
                $display("FAIL %s: actual=%h expected=%h", it.req, observed(), it.v);
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: strobes during reset leave every output at zero.
        @(negedge clk);
        ia_rd = 1'b1; ia_addr = 8'h90; xa_wr = 1'b1;
        repeat (2) @(posedge clk);
        #2;
        total++;
        if (observed() !== 68'd0) begin
            bad++;
            $display("FAIL R1: actual=%h expected=%h", observed(), 68'd0);
        end
        @(negedge clk);
        rst_n = 1'b1; ia_rd = 1'b0; xa_wr = 1'b0;

        issue("R2", 8'h00, 0, 0, 0, 1, 0, 2'd0, 8'h00, 16'h0, 0, 0);
        issue("R2", 8'h7F, 1, 0, 0, 0, 1, 2'd0, 8'h00, 16'h0, 0, 0);
        issue("R3", 8'h80, 1, 0, 0, 1, 0, 2'd0, 8'h11, 16'h0, 0, 0);
        issue("R3", 8'hFF, 1, 0, 0, 0, 1, 2'd0, 8'h00, 16'h0, 0, 0);
        issue("R4", 8'h80, 0, 0, 0, 1, 0, 2'd0, 8'h05, 16'h0, 0, 0);
        issue("R4", 8'hFF, 0, 0, 0, 0, 1, 2'd0, 8'hFF, 16'h0, 0, 0);
        issue("R5", 8'h00, 0, 1, 0, 1, 0, 2'd0, 8'h00, 16'h0, 0, 0);
        issue("R5", 8'h7F, 1, 1, 0, 0, 1, 2'd0, 8'h00, 16'h0, 0, 0);
        issue("R5", 8'h3A, 0, 1, 0, 1, 0, 2'd0, 8'h00, 16'h0, 0, 0);
        issue("R6", 8'h83, 0, 1, 0, 1, 0, 2'd0, 8'h07, 16'h0, 0, 0);
        issue("R6", 8'hF7, 1, 1, 0, 0, 1, 2'd0, 8'hA5, 16'h0, 0, 0);
        issue("R7", 8'h07, 0, 0, 1, 1, 0, 2'd3, 8'h00, 16'h0, 0, 0);
        issue("R7", 8'hFA, 1, 1, 1, 0, 1, 2'd1, 8'h00, 16'h0, 0, 0);
        issue("R7", 8'h00, 0, 0, 1, 1, 0, 2'd2, 8'h00, 16'h0, 0, 0);
        issue("R8", 8'h00, 0, 0, 0, 0, 0, 2'd0, 8'h00, 16'h0000, 1, 0);
        issue("R8", 8'h00, 0, 0, 0, 0, 0, 2'd0, 8'h00, 16'h1FFF, 0, 1);
        issue("R9", 8'h00, 0, 0, 0, 0, 0, 2'd0, 8'h00, 16'h2000, 1, 0);
        issue("R9", 8'h00, 0, 0, 0, 0, 0, 2'd0, 8'h00, 16'hFFFF, 0, 1);
        issue("R10", 8'h85, 1, 0, 0, 1, 0, 2'd0, 8'h00, 16'h4000, 0, 1);
        issue("R10", 8'h10, 0, 0, 0, 0, 1, 2'd0, 8'h00, 16'h0100, 1, 0);
        issue("R11", 8'hC0, 0, 1, 1, 0, 0, 2'd3, 8'h33, 16'h1234, 0, 0);
        issue("R12", 8'h20, 0, 0, 0, 1, 1, 2'd0, 8'h00, 16'h0, 0, 0);
        issue("R12", 8'h00, 0, 0, 0, 0, 0, 2'd0, 8'h00, 16'h3000, 1, 0);
        issue("R11", 8'h00, 0, 0, 0, 0, 0, 2'd0, 8'h00, 16'h0, 0, 0);

        @(negedge clk);
        ia_rd = 1'b0; ia_wr = 1'b0; xa_rd = 1'b0; xa_wr = 1'b0;
        repeat (3) @(posedge clk);
        #3;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule